// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer (SPI Host)

This block is the host side of one conversion on an external 12-bit successive-approximation ADC with a four-wire serial port. A client hands it a request naming an input channel (0 to 3), single-ended or differential input, and unipolar or bipolar coding. The sequencer then drives chip select, serial clock and MOSI itself, shifts in MISO, and returns the 12-bit conversion widened to the result width, together with a one-cycle valid strobe.

A frame is always 24 SCLK cycles with chip select low throughout. The first byte sent is the control byte; the byte that comes back during it carries nothing and is dropped. Two zero bytes follow. The 16 bits returned during those two bytes are one zero, the 12 result bits MSB first, then three zeros. The ADC runs its conversion from the host's SCLK, so the block times the window from the end of the control byte to the last returned bit and flags results that took longer than the droop limit.

Requests use a valid/ready handshake: a request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` stays low until the frame is over. Results have no back-pressure: `res_valid` is a strobe that the client must catch in that cycle.

Top module: `adc_seq_host`

## Requirements
- R1: A request is accepted only on a clock where `req_valid` and `req_ready` are both high; from then until the result strobe, `busy` is high, `req_ready` is low, and any request presented is ignored (no second frame, control byte unchanged).
- R2: The control byte sent first is, from bit 7 down: 1, 0, channel bit 1, channel bit 0, 1 for unipolar / 0 for bipolar, 1 for single-ended / 0 for differential, 1, 1.
- R3: Each frame holds `spi_cs_n` low for exactly 24 SCLK cycles; MOSI carries the control byte and then two bytes of 0x00, MSB first; `spi_cs_n` is high outside frames and after reset.
- R4: SPI mode 0: `spi_sclk` is low whenever `spi_cs_n` is high, MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R5: Each SCLK half period lasts `div_half`+1 clock cycles, with `div_half` taken at request acceptance.
- R6: The 12-bit result is bits 14 down to 3 of the last 16 bits received; the first 8 received bits are discarded.
- R7: For a bipolar request the result is sign-extended to `RES_W` bits from result bit 11; for a unipolar request it is zero-extended.
- R8: `res_timeout` is 1 with the result when more than `TMO_CYC` clock cycles pass between the falling SCLK edge ending the control byte and the 24th rising SCLK edge; otherwise 0.
- R9: `res_valid` is high for exactly one clock, in the same cycle that `spi_cs_n` returns high.
- R10: With `GAP_CYC` = 0 (default) the bytes are sent back to back: rising edges 8 and 9 are one full SCLK period apart, the same as within a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_half | input | DIV_W | SCLK half period minus one, in clock cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_chan | input | 2 | Input channel 0..3 |
| req_diff | input | 1 | 1 = differential pair, 0 = single-ended |
| req_bipolar | input | 1 | 1 = bipolar (two's complement), 0 = unipolar |
| busy | output | 1 | Frame in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Extended conversion result |
| res_timeout | output | 1 | Conversion window exceeded the limit |
| spi_cs_n | output | 1 | ADC chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the ADC |
| spi_miso | input | 1 | Serial data from the ADC |

## Verification
The assertions take for granted that MISO settles before each rising SCLK edge, which holds because the model ADC changes its line only on falling SCLK edges or when chip select falls, and that the request fields are steady while `req_valid` is high, which the driver ensures by setting them with valid at a falling clock edge. They also assume `div_half` is only used at acceptance, so the stimulus changes it only between frames. Divider values are drawn in two disjoint bands, one whose frames fall clearly inside the timeout limit and one clearly beyond it, so the expected flag never depends on a single-cycle boundary.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  localparam int FRAME_BITS = 24;
  localparam int RX_BITS    = 16;
  localparam int ADC_BITS   = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_GAP,
    ST_HOLD
  } seq_state_e;

  function automatic logic [7:0] ctrl_byte(input logic [1:0] chan,
                                           input logic       diff,
                                           input logic       bipolar);
    return {1'b1, 1'b0, chan, ~bipolar, ~diff, 2'b11};
  endfunction

endpackage

// File: rtl/adc_seq_clkdiv.sv
`timescale 1ns/1ps
module adc_seq_clkdiv #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R5: consecutive ticks are half+1 cycles apart
  p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && half != '0) |=> !tick);

endmodule

// File: rtl/adc_seq_watch.sv
`timescale 1ns/1ps
module adc_seq_watch #(
  parameter int LIMIT = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic active,
  output logic late
);

  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);

  logic [CW-1:0] elapsed;

  assign late = (elapsed > CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        elapsed <= '0;
    else if (clear)                    elapsed <= '0;
    else if (active && elapsed != SAT) elapsed <= elapsed + 1'b1;
  end

  // R8: once over the limit the flag stays until the next request clears it
  p_late_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (late && !clear) |=> late);

endmodule

// File: rtl/adc_seq_host.sv
`timescale 1ns/1ps
module adc_seq_host
  import adc_seq_pkg::*;
#(
  parameter int DIV_W   = 10,
  parameter int RES_W   = 16,
  parameter int GAP_CYC = 0,
  parameter int TMO_CYC = 12000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_chan,
  input  logic             req_diff,
  input  logic             req_bipolar,
  output logic             busy,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             res_timeout,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  localparam int BC_W  = $clog2(FRAME_BITS + 1);
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam int EXT_W = RES_W - ADC_BITS;
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(FRAME_BITS);
  localparam logic [BC_W-1:0] CTRL_END = BC_W'(8);

  seq_state_e               state;
  logic [FRAME_BITS-1:0]    txsr;
  logic [RX_BITS-1:0]       rxsr;
  logic [BC_W-1:0]          bitcnt;
  logic [DIV_W-1:0]         half_q;
  logic                     bip_q;
  logic [GAP_W-1:0]         gapcnt;
  logic                     tick, late, run, take, window;
  logic [ADC_BITS-1:0]      sample;
  logic [RES_W-1:0]         widened;

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign take      = req_valid && req_ready;
  assign spi_mosi  = txsr[FRAME_BITS-1];
  assign run       = (state == ST_SETUP) || (state == ST_XFER) || (state == ST_HOLD);

  // conversion window: from the fall ending the control byte to the last rise
  assign window = ((state == ST_XFER) || (state == ST_GAP)) &&
                  (((bitcnt == CTRL_END) && !spi_sclk) ||
                   ((bitcnt > CTRL_END) && (bitcnt < LAST_BIT)));

  assign sample  = rxsr[RX_BITS-2 -: ADC_BITS];
  assign widened = bip_q ? {{EXT_W{sample[ADC_BITS-1]}}, sample}
                         : {{EXT_W{1'b0}}, sample};

  adc_seq_clkdiv #(.DIV_W(DIV_W)) i_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .half (half_q),
    .tick (tick)
  );

  adc_seq_watch #(.LIMIT(TMO_CYC)) i_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (take),
    .active(window),
    .late  (late)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      txsr        <= '0;
      rxsr        <= '0;
      bitcnt      <= '0;
      half_q      <= '0;
      bip_q       <= 1'b0;
      gapcnt      <= '0;
      spi_cs_n    <= 1'b1;
      spi_sclk    <= 1'b0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_timeout <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: if (take) begin
          txsr     <= {ctrl_byte(req_chan, req_diff, req_bipolar), {(FRAME_BITS-8){1'b0}}};
          half_q   <= div_half;
          bip_q    <= req_bipolar;
          bitcnt   <= '0;
          spi_cs_n <= 1'b0;
          state    <= ST_SETUP;
        end
        ST_SETUP: if (tick) state <= ST_XFER;
        ST_XFER: if (tick) begin
          if (!spi_sclk) begin
            spi_sclk <= 1'b1;
            rxsr     <= {rxsr[RX_BITS-2:0], spi_miso};
            bitcnt   <= bitcnt + 1'b1;
          end else begin
            spi_sclk <= 1'b0;
            txsr     <= {txsr[FRAME_BITS-2:0], 1'b0};
            if (bitcnt == LAST_BIT) begin
              state <= ST_HOLD;
            end else if ((GAP_CYC > 0) && (bitcnt[2:0] == 3'd0)) begin
              gapcnt <= '0;
              state  <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gapcnt == GAP_W'(GAP_CYC - 1)) state <= ST_XFER;
          else                               gapcnt <= gapcnt + 1'b1;
        end
        ST_HOLD: if (tick) begin
          spi_cs_n    <= 1'b1;
          res_valid   <= 1'b1;
          res_data    <= widened;
          res_timeout <= late;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: clock idles low outside a frame
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R4: MOSI holds while SCLK is high
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R1: a frame only starts from an accepted request
  p_start_on_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(req_valid && req_ready));

  // R9: single-cycle strobe together with chip select release
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_cs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(spi_cs_n));

  // R3: a result only follows a full frame of rising edges
  p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (bitcnt == LAST_BIT));

endmodule

// File: tb/test_adc_seq_host.sv
`timescale 1ns/1ps
module test_adc_seq_host;

  localparam int DIV_W = 10;
  localparam int RES_W = 16;
  localparam int TMO   = 180;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] div_half = '0;
  logic             req_valid = 1'b0;
  logic [1:0]       req_chan = '0;
  logic             req_diff = 1'b0;
  logic             req_bipolar = 1'b0;
  logic             req_ready, busy, res_valid, res_timeout;
  logic [RES_W-1:0] res_data;
  logic             spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  adc_seq_host #(.DIV_W(DIV_W), .RES_W(RES_W), .GAP_CYC(0), .TMO_CYC(TMO)) i_adc_seq_host (
    .clk(clk), .rst_n(rst_n), .div_half(div_half),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_diff(req_diff), .req_bipolar(req_bipolar), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .res_timeout(res_timeout),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // model ADC: shifts its word out on falling SCLK edges
  logic [23:0] slave_word = '0;
  int nfall;
  always @(negedge spi_sclk or posedge spi_cs_n)
    if (spi_cs_n) nfall <= 0; else nfall <= nfall + 1;
  assign spi_miso = (!spi_cs_n && nfall < 24) ? slave_word[23 - nfall] : 1'b0;

  logic [23:0] mosi_seen = '0;
  int nrise;
  realtime t_rise [0:23];
  always @(posedge spi_sclk or posedge spi_cs_n)
    if (spi_cs_n) nrise <= 0;
    else begin
      mosi_seen <= {mosi_seen[22:0], spi_mosi};
      if (nrise < 24) t_rise[nrise] <= $realtime;
      nrise <= nrise + 1;
    end

  int ncs = 0;
  always @(negedge spi_cs_n) ncs <= ncs + 1;

  function automatic logic [7:0] exp_ctrl(input logic [1:0] ch, input logic dif, input logic bip);
    return {2'b10, ch, ~bip, ~dif, 2'b11};
  endfunction

  function automatic logic [15:0] exp_res(input logic [11:0] d, input logic bip);
    return bip ? {{4{d[11]}}, d} : {4'h0, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic convert(input logic [1:0] ch, input logic dif, input logic bip,
                         input int d, input logic [11:0] data, input logic [7:0] junk,
                         input bit poke, input bit exp_late);
    int wait_n;
    int cs_before;
    int period;
    slave_word = {junk, 1'b0, data, 3'b000};
    @(negedge clk);
    div_half = DIV_W'(d);
    req_chan = ch; req_diff = dif; req_bipolar = bip; req_valid = 1'b1;
    cs_before = ncs;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && busy, "R1 busy after accept", {30'd0, req_ready, busy}, 32'h1);
    chk(!spi_cs_n, "R3 cs low in frame", 32'(spi_cs_n), 32'h0);
    if (poke) begin
      repeat (30) @(negedge clk);
      req_chan = ~ch; req_diff = ~dif; req_bipolar = ~bip; req_valid = 1'b1;
      chk(!req_ready, "R1 ready low mid-frame", 32'(req_ready), 32'h0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    wait_n = 0;
    while (!res_valid && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    if (!res_valid) begin
      chk(1'b0, "R9 result watchdog expired", 32'(wait_n), 32'd5000);
      return;
    end
    chk(res_data == exp_res(data, bip), bip ? "R7 R6 bipolar result" : "R7 R6 unipolar result",
        32'(res_data), 32'(exp_res(data, bip)));
    chk(res_timeout == exp_late, "R8 timeout flag", 32'(res_timeout), 32'(exp_late));
    chk(spi_cs_n && !spi_sclk, "R9 R4 cs high sclk low at strobe", {30'd0, spi_cs_n, spi_sclk}, 32'h2);
    chk(mosi_seen == {exp_ctrl(ch, dif, bip), 16'h0000}, "R2 R3 MOSI frame",
        32'(mosi_seen), 32'({exp_ctrl(ch, dif, bip), 16'h0000}));
    chk(ncs - cs_before == 1, "R1 one frame per request", 32'(ncs - cs_before), 32'd1);
    period = int'((t_rise[1] - t_rise[0]) / 20.0);
    chk(period == 2 * (d + 1), "R5 SCLK period", 32'(period), 32'(2 * (d + 1)));
    period = int'((t_rise[8] - t_rise[7]) / 20.0);
    chk(period == 2 * (d + 1), "R10 byte boundary spacing", 32'(period), 32'(2 * (d + 1)));
    @(negedge clk);
    chk(!res_valid && req_ready, "R9 R1 strobe single cycle", {30'd0, res_valid, req_ready}, 32'h1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = 13;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sclk, "R3 R4 reset pins", {30'd0, spi_cs_n, spi_sclk}, 32'h2);
    chk(req_ready && !busy && !res_valid, "R1 R9 reset handshake",
        {29'd0, req_ready, busy, res_valid}, 32'h4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    convert(2'd0, 1'b0, 1'b1, 0, 12'h800, 8'hFF, 1'b0, 1'b0);
    convert(2'd3, 1'b1, 1'b0, 1, 12'hFFF, 8'hA5, 1'b0, 1'b0);
    convert(2'd1, 1'b0, 1'b1, 4, 12'h7FF, 8'h00, 1'b0, 1'b0);
    convert(2'd2, 1'b1, 1'b1, 2, 12'h001, 8'h3C, 1'b1, 1'b0);
    convert(2'd1, 1'b1, 1'b0, 8, 12'h5A5, 8'h81, 1'b0, 1'b1);
    convert(2'd2, 1'b0, 1'b0, 3, 12'h123, 8'h7E, 1'b0, 1'b0);
    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [1:0]  ch;
      logic        dif, bip, slow;
      logic [11:0] dat;
      logic [7:0]  jk;
      int          d;
      ch   = 2'($urandom);
      dif  = 1'($urandom);
      bip  = 1'($urandom);
      dat  = 12'($urandom);
      jk   = 8'($urandom);
      slow = ($urandom % 6) == 0;
      d    = slow ? 7 + int'($urandom % 3) : int'($urandom % 5);
      convert(ch, dif, bip, d, dat, jk, ($urandom % 4) == 0, slow);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule